// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken by using both the branch's own past behaviour and the outcomes of the two most recent branches anywhere in the program. A single shared 2-bit history register records the last two resolved outcomes. Each tracked branch owns four 1-bit predictors, one for each possible history pattern. When a prediction is asked for, the history picks which of the four predictors answers.

The prediction is asked for with a branch identifier. It comes back combinationally from the current state. When the branch resolves, an update carries the same identifier and the real outcome. The update overwrites the one predictor that the current history selects, and it shifts the outcome into the shared history. An inspection port returns the four predictors of any branch as a packed nibble, so that software models or a bench can follow the state.

Top module: `corrbp_top`

## Requirements
- R1: While `rst` is high at a clock edge, the history becomes 00 and every predictor of every branch becomes 0 (not taken).
- R2: `predTaken` equals the predictor of branch `predId` at the position that the current history `histOut` selects, with 1 meaning taken.
- R3: `inspState` holds the four predictors of branch `inspId` as {W,X,Y,Z}. Bit 3 (W) is used when both earlier outcomes were taken (history 11). Bit 2 (X) is used when the last outcome was taken and the one before was not (history 01). Bit 1 (Y) is used when the last outcome was not taken and the one before was (history 10). Bit 0 (Z) is used when both were not taken (history 00).
- R4: An update (`updValid` high) writes `updTaken` into the predictor of branch `updId` at the position the pre-update history selects. The other three predictors of that branch keep their values.
- R5: An update leaves the predictors of every other branch unchanged.
- R6: After an update, `histOut` is {previous last bit, `updTaken`}. The history is written {older, last}, and the older bit drops out.
- R7: A cycle with `updValid` low changes neither the history nor any predictor, whatever `updId` and `updTaken` carry.
- R8: When a prediction and an update name the same branch in the same cycle, `predTaken` reflects the state from before that update.
- R9: The history is shared by all branches, so an update to one branch changes which predictor is selected for every other branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| predId | input | ID_W | Branch to predict |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | Update strobe |
| updId | input | ID_W | Branch being resolved |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| inspId | input | ID_W | Branch whose state is shown |
| inspState | output | 4 | Predictors {W,X,Y,Z} of `inspId` |
| histOut | output | 2 | Global history {older, last} |

## Verification
The bench builds the block with its default ID_W of 2, which gives four branches. At that size, every branch can be read back through the inspection port after each update. This is what lets the bench confirm that an update leaves the other branches untouched. A replay of a nested loop (an inner branch taken three times and then not taken, then an outer branch) drives the shared history through all four patterns. As a result, all of W, X, Y and Z are written and read within a short sequence.

// File: rtl/corrbp_pkg.sv
package corrbp_pkg;
  localparam int HIST_W = 2;
  localparam int PAT_N  = 1 << HIST_W;

  typedef struct packed {
    logic             wrEn;
    logic [HIST_W-1:0] wrPos;
    logic             wrVal;
  } bpStrobe_t;

  // History {older,last} -> bit position in the packed {W,X,Y,Z} word
  function automatic logic [HIST_W-1:0] patPos(input logic [HIST_W-1:0] h);
    return {h[0], h[1]};
  endfunction
endpackage

// File: rtl/corrbp_ctrl.sv
module corrbp_ctrl
  import corrbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              updValid,
  input  logic              updTaken,
  output bpStrobe_t         stb,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] histQ;

  always_ff @(posedge clk) begin
    if (rst)           histQ <= '0;
    else if (updValid) histQ <= {histQ[HIST_W-2:0], updTaken};
  end

  always_comb begin
    stb.wrEn  = updValid;
    stb.wrPos = patPos(histQ);
    stb.wrVal = updTaken;
  end

  assign hist = histQ;

  assert_hist_reset_R1: assert property (@(posedge clk) rst |=> hist == '0);
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    updValid |=> hist == {$past(hist[0]), $past(updTaken)});
  assert_hist_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !updValid |=> $stable(hist));
endmodule

// File: rtl/corrbp_dpath.sv
module corrbp_dpath
  import corrbp_pkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bpStrobe_t         stb,
  input  logic [ID_W-1:0]   updId,
  input  logic [ID_W-1:0]   predId,
  input  logic [ID_W-1:0]   inspId,
  input  logic [HIST_W-1:0] hist,
  output logic              predTaken,
  output logic [PAT_N-1:0]  inspState
);
  localparam int NUM_BR = 1 << ID_W;

  logic [PAT_N-1:0] tbl [NUM_BR];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BR; i++) begin
      if (rst) tbl[i] <= '0;
      else if (stb.wrEn && updId == ID_W'(i)) tbl[i][stb.wrPos] <= stb.wrVal;
    end
  end

  assign predTaken = tbl[predId][patPos(hist)];
  assign inspState = tbl[inspId];

  for (genvar g = 0; g < NUM_BR; g++) begin : gChk
    assert_entry_write_R4: assert property (@(posedge clk) disable iff (rst)
      (stb.wrEn && updId == ID_W'(g)) |=> tbl[g][$past(stb.wrPos)] == $past(stb.wrVal));
    assert_other_branch_R5: assert property (@(posedge clk) disable iff (rst)
      (stb.wrEn && updId != ID_W'(g)) |=> $stable(tbl[g]));
    assert_entry_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !stb.wrEn |=> $stable(tbl[g]));
    assert_entry_reset_R1: assert property (@(posedge clk) rst |=> tbl[g] == '0);
  end
endmodule

// File: rtl/corrbp_top.sv
module corrbp_top
  import corrbp_pkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] predId,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [ID_W-1:0] updId,
  input  logic            updTaken,
  input  logic [ID_W-1:0] inspId,
  output logic [3:0]      inspState,
  output logic [1:0]      histOut
);
  bpStrobe_t stb;

  corrbp_ctrl ctrl_i (
    .clk(clk), .rst(rst), .updValid(updValid), .updTaken(updTaken),
    .stb(stb), .hist(histOut)
  );

  corrbp_dpath #(.ID_W(ID_W)) dpath_i (
    .clk(clk), .rst(rst), .stb(stb), .updId(updId), .predId(predId),
    .inspId(inspId), .hist(histOut), .predTaken(predTaken), .inspState(inspState)
  );
endmodule

// File: tb/corrbp_top_tb_top.sv
module corrbp_top_tb_top;
  logic clk = 0;
  logic rst;
  logic [1:0] predId, updId, inspId;
  logic predTaken, updValid, updTaken;
  logic [3:0] inspState;
  logic [1:0] histOut;
  int nChk = 0, nFail = 0;

  always #2 clk = ~clk;

  corrbp_top dut_i (.*);

  // Bench model: {id, taken} per step
  localparam int NV = 16;
  localparam logic [2:0] VEC [NV] = '{
    3'b011, 3'b011, 3'b011, 3'b010, 3'b101,
    3'b011, 3'b011, 3'b011, 3'b010, 3'b100,
    3'b001, 3'b110, 3'b111, 3'b000, 3'b111, 3'b001};

  logic [3:0] mTbl [4];
  logic [1:0] mHist;

  function automatic int pos(input logic [1:0] h);
    return {h[0], h[1]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int b = 0; b < 4; b++) begin
      inspId = 2'(b); #0.1;
      chk(req, inspState, mTbl[b]);
    end
    chk("R6", histOut, mHist);
  endtask

  task automatic step(input logic [1:0] id, input logic tk, input logic vld);
    @(negedge clk);
    updValid = vld; updId = id; updTaken = tk; predId = id; #0.5;
    chk("R2", predTaken, mTbl[id][pos(mHist)]);
    @(posedge clk); #0.5;
    if (vld) begin
      mTbl[id][pos(mHist)] = tk;
      mHist = {mHist[0], tk};
    end
    updValid = 0;
  endtask

  initial begin
    #100000;
    nFail++; nChk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    rst = 1; updValid = 0; updId = 0; updTaken = 0; predId = 0; inspId = 0;
    for (int b = 0; b < 4; b++) mTbl[b] = '0;
    mHist = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    checkAll("R1");

    // R3: explicit packed positions on branch 0
    step(0, 1, 1); inspId = 0; #0.1; chk("R3 Z", inspState, 4'b0001);
    step(0, 1, 1); inspId = 0; #0.1; chk("R3 X", inspState, 4'b0101);
    step(0, 1, 1); inspId = 0; #0.1; chk("R3 W", inspState, 4'b1101);
    step(0, 0, 1); inspId = 0; #0.1; chk("R3 W clr", inspState, 4'b0101);
    step(0, 1, 1); inspId = 0; #0.1; chk("R3 Y", inspState, 4'b0111);
    chk("R6", histOut, 2'b01);

    // Vector walk: R2, R4, R5, R6, R9
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][2:1], VEC[v][0], 1);
      checkAll("R4/R5");
    end

    // R7: idle cycle with busy inputs
    step(2, ~mTbl[2][pos(mHist)], 0);
    checkAll("R7");

    // R8: same-cycle predict/update with flipping outcome
    begin
      logic old;
      @(negedge clk);
      old = mTbl[3][pos(mHist)];
      predId = 3; updId = 3; updTaken = ~old; updValid = 1; #0.5;
      chk("R8", predTaken, old);
      @(posedge clk); #0.5;
      mTbl[3][pos(mHist)] = ~old; mHist = {mHist[0], ~old};
      updValid = 0;
      checkAll("R8");
    end

    // R9: update on branch 1 changes selection for branch 2
    step(1, 1, 1); step(1, 1, 1);
    step(2, 1, 1);
    step(1, 0, 1);
    predId = 2; #0.1; chk("R9", predTaken, mTbl[2][pos(mHist)]);

    // R1 again mid-run
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    for (int b = 0; b < 4; b++) mTbl[b] = '0;
    mHist = 0;
    checkAll("R1");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule